// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block watches CPU writes into the banked program window of a parallel flash part and decodes the unlock-and-command write sequences that such parts expect. The write address is the 19-bit flash address, built from the 4-bit program bank and the low 15 CPU address bits. A write that matches a known sequence becomes one request on a memory-port interface: program one byte, erase one 4 KB sector, or erase the whole chip. The memory side carries out the request. The flash array itself and its program and erase timing lie outside the block.

The block also tracks a software-identification mode. While that mode is on, it supplies replacement read data for the program window: a manufacturer byte, a device byte and filler. The read logic downstream selects this data over the array whenever `id_mode_o` is high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller waits for the first unlock write, `id_mode_o` is 0 and `op_valid_o` is 0.
- R2: Unlock and command-address checks use only the low 15 bits of `wr_addr_i`. Bits 18:15 (the bank) do not affect whether a sequence is accepted.
- R3: While the controller is idle, a write of 0xF0 that is not the first unlock write (0xAA at 0x5555) clears ID mode.
- R4: A command needs 0xAA at 0x5555, then 0x55 at 0x2AAA, then a command byte at 0x5555. If any step does not match, the controller returns to idle and issues no request.
- R5: Command bytes are decoded as follows. 0xA0 arms a byte program. 0x80 arms an erase. 0x90 sets ID mode. 0xF0 clears ID mode. Any other value returns to idle and issues no request.
- R6: The write that follows an armed byte program issues a request of kind 2'b01 carrying the full 19-bit address and the write data. The memory then holds the old byte AND the data, so a program can only clear bits.
- R7: An armed erase requires 0xAA at 0x5555 and then 0x55 at 0x2AAA. A third write of 0x10 at 0x5555 issues a chip erase, kind 2'b11, with address 0. Otherwise, a third write of 0x30 at any address issues a sector erase, kind 2'b10, whose address is the write address with bits 11:0 cleared. Both erase kinds carry data 0xFF. Any other third write issues no request. A sector erase leaves every other sector unchanged.
- R8: `id_data_o` depends only on `rd_addr_i[8:0]`: 0xBF at offset 0, 0xB7 at offset 1 and 0xFF at every other offset. The pattern repeats every 512 bytes.
- R9: Requests and `id_mode_o` change in the clock cycle after the write that causes them. `op_valid_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle strobe for a CPU write into the program window |
| wr_addr_i | input | 19 | Bank-extended flash address of the write |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 19 | Flash address of the current read |
| op_valid_o | output | 1 | Request pulse |
| op_kind_o | output | 2 | 01 program, 10 sector erase, 11 chip erase |
| op_addr_o | output | 19 | Request address |
| op_data_o | output | 8 | Request data (0xFF for erases) |
| id_mode_o | output | 1 | ID mode active; read data must come from `id_data_o` |
| id_data_o | output | 8 | Replacement read data for ID mode |

## Verification
The assertions assume that `wr_en_i` is a clean strobe sampled on the clock, and that address and data are stable and meaningful whenever it is high. They also assume that ID mode is valid only while no write is pending. The stimulus drives each write for one cycle with an idle cycle after it, and changes inputs only on the falling edge. This keeps every request pulse apart from the next write and lets the memory model in the bench apply each request before the following command begins.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_UNLOCK  = 2'd1,
    ST_PROG    = 2'd2,
    ST_ERASE   = 2'd3
  } fsm_state_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SECTOR = 2'd2,
    OP_CHIP   = 2'd3
  } op_kind_e;

  localparam logic [14:0] ADDR_KEY_A = 15'h5555;
  localparam logic [14:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [DATA_W-1:0] D_KEY_A     = 8'hAA;
  localparam logic [DATA_W-1:0] D_KEY_B     = 8'h55;
  localparam logic [DATA_W-1:0] D_CMD_PROG  = 8'hA0;
  localparam logic [DATA_W-1:0] D_CMD_ERASE = 8'h80;
  localparam logic [DATA_W-1:0] D_CMD_ID    = 8'h90;
  localparam logic [DATA_W-1:0] D_CMD_EXIT  = 8'hF0;
  localparam logic [DATA_W-1:0] D_ER_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] D_ER_SECTOR = 8'h30;
  localparam logic [DATA_W-1:0] D_ID_MFR    = 8'hBF;
  localparam logic [DATA_W-1:0] D_ID_DEV    = 8'hB7;
  localparam logic [DATA_W-1:0] D_FILL      = 8'hFF;
endpackage

// File: rtl/flash_key_match.sv
module flash_key_match
  import flash_cmd_pkg::*;
#(
  parameter int CMD_AW = 15
) (
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              key_a_o,
  output logic              key_b_o,
  output logic              at_cmd_o
);
  assign at_cmd_o = (addr_i == ADDR_KEY_A[CMD_AW-1:0]);
  assign key_a_o  = at_cmd_o && (data_i == D_KEY_A);
  assign key_b_o  = (addr_i == ADDR_KEY_B[CMD_AW-1:0]) && (data_i == D_KEY_B);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              key_a_i,
  input  logic              key_b_i,
  input  logic              at_cmd_i,
  output op_kind_e          req_kind_o,
  output logic              id_mode_o
);
  fsm_state_e state_q, state_d;
  logic [1:0] step_q, step_d;
  logic       id_q, id_d;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    id_d       = id_q;
    req_kind_o = OP_NONE;
    if (wr_en_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (key_a_i) begin
            state_d = ST_UNLOCK;
            step_d  = 2'd0;
          end else if (data_i == D_CMD_EXIT) begin
            id_d = 1'b0;
          end
        end
        ST_UNLOCK: begin
          if (step_q == 2'd0) begin
            if (key_b_i) step_d = 2'd1;
            else         state_d = ST_IDLE;
          end else begin
            state_d = ST_IDLE;
            step_d  = 2'd0;
            if (at_cmd_i) begin
              case (data_i)
                D_CMD_PROG:  state_d = ST_PROG;
                D_CMD_ERASE: state_d = ST_ERASE;
                D_CMD_ID:    id_d = 1'b1;
                D_CMD_EXIT:  id_d = 1'b0;
                default:     ;
              endcase
            end
          end
        end
        ST_PROG: begin
          req_kind_o = OP_PROG;
          state_d    = ST_IDLE;
        end
        ST_ERASE: begin
          if (step_q == 2'd0) begin
            if (key_a_i) step_d = 2'd1;
            else         state_d = ST_IDLE;
          end else if (step_q == 2'd1) begin
            if (key_b_i) step_d = 2'd2;
            else         state_d = ST_IDLE;
          end else begin
            if (at_cmd_i && data_i == D_ER_CHIP) req_kind_o = OP_CHIP;
            else if (data_i == D_ER_SECTOR)      req_kind_o = OP_SECTOR;
            state_d = ST_IDLE;
            step_d  = 2'd0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      id_q    <= id_d;
    end
  end

  assign id_mode_o = id_q;
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int PERIOD_AW = 9
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] id_data_o
);
  logic [PERIOD_AW-1:0] offs;
  assign offs = rd_addr_i[PERIOD_AW-1:0];

  always_comb begin
    if (offs == PERIOD_AW'(0))      id_data_o = D_ID_MFR;
    else if (offs == PERIOD_AW'(1)) id_data_o = D_ID_DEV;
    else                            id_data_o = D_FILL;
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int CMD_AW    = 15,
  parameter int SECTOR_AW = 12,
  parameter int PERIOD_AW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              op_valid_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o
);
  localparam int SEC_HI_W = ADDR_W - SECTOR_AW;

  logic     key_a, key_b, at_cmd;
  op_kind_e req_kind;

  flash_key_match #(.CMD_AW(CMD_AW)) u_match (
    .addr_i  (wr_addr_i[CMD_AW-1:0]),
    .data_i  (wr_data_i),
    .key_a_o (key_a),
    .key_b_o (key_b),
    .at_cmd_o(at_cmd)
  );

  flash_cmd_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .data_i    (wr_data_i),
    .key_a_i   (key_a),
    .key_b_i   (key_b),
    .at_cmd_i  (at_cmd),
    .req_kind_o(req_kind),
    .id_mode_o (id_mode_o)
  );

  flash_id_rom #(.ADDR_W(ADDR_W), .PERIOD_AW(PERIOD_AW)) u_id (
    .rd_addr_i(rd_addr_i),
    .id_data_o(id_data_o)
  );

  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        data_d;

  always_comb begin
    unique case (req_kind)
      OP_PROG: begin
        addr_d = wr_addr_i;
        data_d = wr_data_i;
      end
      OP_SECTOR: begin
        addr_d = {wr_addr_i[ADDR_W-1:SECTOR_AW], {SECTOR_AW{1'b0}}};
        data_d = D_FILL;
      end
      OP_CHIP: begin
        addr_d = '0;
        data_d = D_FILL;
      end
      default: begin
        addr_d = '0;
        data_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0;
      op_kind_o  <= OP_NONE;
      op_addr_o  <= '0;
      op_data_o  <= '0;
    end else begin
      op_valid_o <= (req_kind != OP_NONE);
      op_kind_o  <= req_kind;
      if (req_kind != OP_NONE) begin
        op_addr_o <= addr_d;
        op_data_o <= data_d;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W    = 19,
  parameter int SECTOR_AW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              op_valid_o,
  input logic [1:0]        op_kind_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic [7:0]        op_data_o,
  input logic              id_mode_o,
  input logic [7:0]        id_data_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_en_i));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);

  p_kind_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_kind_o != 2'b00));

  p_prog_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == 2'b01) |-> (op_data_o == $past(wr_data_i) && op_addr_o == $past(wr_addr_i)));

  p_sector_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == 2'b10) |-> (op_addr_o[SECTOR_AW-1:0] == '0 && $past(wr_data_i) == 8'h30));

  p_chip_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == 2'b11) |-> ($past(wr_data_i) == 8'h10 && $past(wr_addr_i[14:0]) == 15'h5555));

  p_id_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(id_mode_o));

  p_id_mfr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[8:0] == 9'd0) |-> (id_data_o == 8'hBF));

  p_id_dev_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[8:0] == 9'd1) |-> (id_data_o == 8'hB7));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .SECTOR_AW(SECTOR_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_addr_i (rd_addr_i),
  .op_valid_o(op_valid_o),
  .op_kind_o (op_kind_o),
  .op_addr_o (op_addr_o),
  .op_data_o (op_data_o),
  .id_mode_o (id_mode_o),
  .id_data_o (id_data_o)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int ADDR_W    = 19;
  localparam int MEM_AW    = 13;
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int SEC_SZ    = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              op_valid;
  logic [1:0]        op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              id_mode;
  logic [7:0]        id_data;

  always #5 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .op_valid_o(op_valid),
    .op_kind_o (op_kind),
    .op_addr_o (op_addr),
    .op_data_o (op_data),
    .id_mode_o (id_mode),
    .id_data_o (id_data)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] mem [MEM_DEPTH];

  logic [1:0]        exp_kind_q[$];
  logic [ADDR_W-1:0] exp_addr_q[$];
  logic [7:0]        exp_data_q[$];
  string             exp_tag_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input string req, input logic [1:0] k, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    exp_kind_q.push_back(k);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(d);
    exp_tag_q.push_back(req);
  endtask

  // monitor: pop expected request, compare, apply to memory model
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      if (exp_kind_q.size() == 0) begin
        chk("R4 unexpected request kind", {30'd0, op_kind}, 32'd0);
      end else begin
        string t;
        t = exp_tag_q.pop_front();
        chk({t, " kind"}, {30'd0, op_kind}, {30'd0, exp_kind_q.pop_front()});
        chk({t, " addr"}, {13'd0, op_addr}, {13'd0, exp_addr_q.pop_front()});
        chk({t, " data"}, {24'd0, op_data}, {24'd0, exp_data_q.pop_front()});
      end
      case (op_kind)
        2'b01: mem[op_addr[MEM_AW-1:0]] = mem[op_addr[MEM_AW-1:0]] & op_data;
        2'b10: for (int i = 0; i < SEC_SZ; i++)
                 mem[(int'(op_addr[MEM_AW-1:0]) & ~(SEC_SZ-1)) + i] = 8'hFF;
        2'b11: for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 8'hFF;
        default: ;
      endcase
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock(input logic [3:0] bank, input logic [7:0] cmd);
    wr({bank, 15'h5555}, 8'hAA);
    wr({bank, 15'h2AAA}, 8'h55);
    wr({bank, 15'h5555}, cmd);
  endtask

  task automatic drained(input string req);
    idle(2);
    chk({req, " pending requests"}, exp_kind_q.size(), 0);
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  bit done = 1'b0;

  initial begin
    logic [7:0] e;
    int bad;
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = init_val(i);
    idle(3);
    chk("R1 op_valid at reset", op_valid, 0);
    chk("R1 id_mode at reset", id_mode, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 op_valid after reset", op_valid, 0);

    // R6 program, then re-program clears bits only
    unlock(4'h0, 8'hA0);
    push("R6 prog1", 2'b01, 19'h00123, 8'h0F);
    wr(19'h00123, 8'h0F);
    drained("R6");
    e = init_val('h123) & 8'h0F;
    chk("R6 first program AND", mem['h123], e);
    unlock(4'h0, 8'hA0);
    push("R6 prog2", 2'b01, 19'h00123, 8'hF5);
    wr(19'h00123, 8'hF5);
    drained("R6");
    e = e & 8'hF5;
    chk("R6 second program clears only", mem['h123], e);

    // R2 bank bits ignored by unlock
    unlock(4'hB, 8'hA0);
    push("R2 banked prog", 2'b01, 19'h48456, 8'h81);
    wr(19'h48456, 8'h81);
    drained("R2");
    chk("R2 banked program result", mem['h456], init_val('h456) & 8'h81);

    // R4 aborted sequences
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h12);
    wr(19'h00200, 8'h00);
    drained("R4 bad data");
    chk("R4 abort data leaves byte", mem['h200], init_val('h200));
    wr(19'h05555, 8'hAA);
    wr(19'h02AAB, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h00201, 8'h00);
    drained("R4 bad addr");
    chk("R4 abort addr leaves byte", mem['h201], init_val('h201));

    // R5 unknown command
    unlock(4'h0, 8'h77);
    wr(19'h00202, 8'h00);
    drained("R5 unknown cmd");
    chk("R5 unknown cmd leaves byte", mem['h202], init_val('h202));

    // R5/R8 ID mode
    unlock(4'h0, 8'h90);
    chk("R5 id enter", id_mode, 1);
    rd_addr = 19'h00000; #1 chk("R8 offset 0", id_data, 8'hBF);
    rd_addr = 19'h00001; #1 chk("R8 offset 1", id_data, 8'hB7);
    rd_addr = 19'h00002; #1 chk("R8 offset 2", id_data, 8'hFF);
    rd_addr = 19'h00200; #1 chk("R8 repeat 0", id_data, 8'hBF);
    rd_addr = 19'h3FE01; #1 chk("R8 repeat 1", id_data, 8'hB7);
    rd_addr = 19'h001FF; #1 chk("R8 offset 1FF", id_data, 8'hFF);
    wr(19'h01234, 8'h00);
    chk("R3 other write keeps id", id_mode, 1);
    wr(19'h01234, 8'hF0);
    chk("R3 bare F0 exits id", id_mode, 0);
    unlock(4'h2, 8'h90);
    chk("R5 id re-enter", id_mode, 1);
    unlock(4'h0, 8'hF0);
    chk("R5 F0 command exits id", id_mode, 0);
    drained("R5 id");

    // R7 sector erase, neighbour sector kept
    unlock(4'h0, 8'h80);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    push("R7 sector", 2'b10, 19'h51000, 8'hFF);
    wr(19'h51234, 8'h30);
    drained("R7 sector");
    bad = 0;
    for (int i = SEC_SZ; i < 2*SEC_SZ; i++) if (mem[i] !== 8'hFF) bad++;
    chk("R7 erased sector all FF", bad, 0);
    chk("R7 neighbour byte 0", mem[0], init_val(0));
    chk("R7 neighbour programmed", mem['h123], e);
    chk("R7 neighbour last", mem['hFFF], init_val('hFFF));

    // R7 erase aborts
    unlock(4'h0, 8'h80);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    wr(19'h02AAA, 8'h10);
    unlock(4'h0, 8'h80);
    wr(19'h05555, 8'h00);
    wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'h30);
    drained("R7 aborts");
    chk("R7 aborted erase keeps byte", mem[0], init_val(0));

    // R7 chip erase
    unlock(4'h0, 8'h80);
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
    push("R7 chip", 2'b11, 19'h00000, 8'hFF);
    wr(19'h75555, 8'h10);
    drained("R7 chip");
    bad = 0;
    for (int i = 0; i < MEM_DEPTH; i++) if (mem[i] !== 8'hFF) bad++;
    chk("R7 chip erase all FF", bad, 0);
    chk("R9 no pulse at rest", op_valid, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule